// File: doc/BRIEF.md
# Predictive Error-Feedback Requantizer

This block cuts a stream of signed 12-bit samples down to signed 4-bit samples. It shapes the rounding noise so that it moves out of a frequency band chosen by the user. It does this by measuring the error of every quantization decision and passing that error through a short FIR predictor with programmable weights. The prediction is added to the next input sample before that sample is quantized. When the predictor has unit gain and leading phase in the band of interest, the noise cancels inside that band. A downstream filter can then run with 4-bit data multipliers and still keep the in-band dynamic range.

The predictor sits inside the feedback loop, so its output must be ready in the same cycle it is used. Each weight multiply is therefore a bank of 16-entry tables of scaled coefficient values, addressed 4 bits at a time and summed with shifts, with no pipeline registers. The partial sums form a transposed accumulate-delay chain. One sample is accepted per clock while `in_valid` is high. Coefficients are written one tap at a time through the load port, only while no sample is being accepted. Changing the weights moves the noise notch to a lowpass, bandpass or highpass centre.

Top module: `erq_requantizer`

## Requirements
- R1: After reset, `out_valid` and `out_sample` are 0, the predictor state is cleared and every coefficient is 0. Until a coefficient is loaded, each output is the plain rounded and saturated quantization of its input.
- R2: The quantizer output is q = clamp(floor((v + 128) / 256), -8, 7), where v is the 16-bit loop sum. `out_sample` carries q as a 4-bit two's complement code, so 4'b0111 is +7 and 4'b1000 is -8.
- R3: A sample accepted on a rising edge with `in_valid` high produces its code on `out_sample`, with `out_valid` high, from that same edge until the next one. `out_valid` is the input valid delayed by one register.
- R4: The quantization error is e = v - 256*q. The loop sum is v = x + p, with p(n) = floor(sum over k of a_k * e(n-1-k) / 1024). With only a_0 = 1024 and a constant input of 100, the first eight codes are 0,1,0,1,0,0,1,0.
- R5: `coef_idx` = k writes the weight a_k of tap k, which multiplies e(n-1-k). `coef_val` is 12-bit two's complement with 10 fractional bits, covering -2.0 to just under +2.0. A loaded weight applies from the next accepted sample onward.
- R6: A coefficient write is ignored when `in_valid` is high on that edge, or when `coef_idx` is 9 or more.
- R7: The prediction p and the loop sum v both saturate to the signed 16-bit range [-32768, 32767] rather than wrapping.
- R8: While `in_valid` is low, `out_valid` goes low, `out_sample` keeps its last code and the predictor state does not change. The output sequence is the same as if the idle cycles were absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sample per cycle at most |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Accept `in_sample` on this edge |
| in_sample | input | 12 | Signed input sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | 4 | Tap index for the write |
| coef_val | input | 12 | Signed weight, 10 fractional bits |
| out_valid | output | 1 | `out_sample` holds a new code |
| out_sample | output | 4 | Signed requantized sample |

## Verification
The case that is hardest to reach from the ports is saturation of the 16-bit loop sum. With stable weights and full-scale input, the error stays within one quantization step and the sum never comes close to its limits. The bench reaches saturation by loading every tap with the largest positive weight and driving full-scale input of both signs, which makes the loop grow until the prediction and the sum clip. It then compares every code against an independent arithmetic model, so any wrap-around shows up as a sign flip in the output. Writes attempted during valid samples and writes to out-of-range taps are checked through the output codes of the samples that follow.

// File: rtl/erq_pkg.sv
// Shared constants and helpers for the predictive requantizer.
// Assumes a nibble-wide table lookup for every constant multiply.
package erq_pkg;

    localparam int NIB_W     = 4;
    localparam int LUT_DEPTH = 1 << NIB_W;

    // Number of nibbles needed to cover an operand of the given width.
    function automatic int nibble_count(input int width);
        return (width + NIB_W - 1) / NIB_W;
    endfunction

    // Width of an index able to address the given number of items.
    function automatic int index_width(input int items);
        return (items > 1) ? $clog2(items) : 1;
    endfunction

endpackage

// File: rtl/erq_coef_table.sv
// Holds one tap's table of scaled coefficient values: entry i is coef*i.
// Entry 1 is the coefficient itself. The table is rewritten whole on a load
// and cleared by reset. Assumes load_en is already qualified by the caller.
module erq_coef_table #(
    parameter int COEF_W = 12,
    parameter int ENT_W  = COEF_W + erq_pkg::NIB_W
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  load_en,
    input  logic signed [COEF_W-1:0]              load_val,
    output logic [erq_pkg::LUT_DEPTH*ENT_W-1:0]   entries_flat
);
    localparam int DEPTH = erq_pkg::LUT_DEPTH;

    logic signed [ENT_W-1:0] ent_q [DEPTH];
    logic signed [ENT_W-1:0] ent_d [DEPTH];

    // Form every multiple of the incoming coefficient.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ent_d[i] = $signed(ENT_W'(load_val)) * $signed(ENT_W'(i));
        end
    end

    // Store the table on a qualified load; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else if (load_en) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign entries_flat[g*ENT_W +: ENT_W] = ent_q[g];
    end

endmodule

// File: rtl/erq_nibble_mult.sv
// Zero-latency constant multiply: the signed operand is split into nibbles,
// each nibble picks a table entry, and the entries are added with shifts.
// The top nibble is signed, so its weight is corrected by subtracting coef*16.
// Assumes PROD_W covers the padded operand width plus COEF_W.
module erq_nibble_mult #(
    parameter int OPND_W = 17,
    parameter int COEF_W = 12,
    parameter int ENT_W  = COEF_W + erq_pkg::NIB_W,
    parameter int PROD_W = erq_pkg::nibble_count(OPND_W) * erq_pkg::NIB_W + COEF_W
) (
    input  logic [erq_pkg::LUT_DEPTH*ENT_W-1:0] entries_flat,
    input  logic signed [OPND_W-1:0]            operand,
    output logic signed [PROD_W-1:0]            product
);
    localparam int NIB_W = erq_pkg::NIB_W;
    localparam int DEPTH = erq_pkg::LUT_DEPTH;
    localparam int NIBS  = erq_pkg::nibble_count(OPND_W);
    localparam int PAD_W = NIBS * NIB_W;

    logic signed [ENT_W-1:0]  lut [DEPTH];
    logic signed [PAD_W-1:0]  opnd_pad;
    logic signed [PROD_W-1:0] partial [NIBS];

    for (genvar g = 0; g < DEPTH; g++) begin : g_unpack
        assign lut[g] = entries_flat[g*ENT_W +: ENT_W];
    end

    assign opnd_pad = PAD_W'(operand);

    for (genvar j = 0; j < NIBS; j++) begin : g_nib
        logic [NIB_W-1:0]         nib;
        logic signed [PROD_W-1:0] base;
        assign nib  = opnd_pad[j*NIB_W +: NIB_W];
        assign base = PROD_W'(lut[nib]) <<< (j * NIB_W);
        if (j == NIBS - 1) begin : g_top
            logic signed [PROD_W-1:0] corr;
            assign corr       = nib[NIB_W-1] ? (PROD_W'(lut[1]) <<< (NIBS * NIB_W)) : '0;
            assign partial[j] = base - corr;
        end else begin : g_low
            assign partial[j] = base;
        end
    end

    // Sum the shifted partial products.
    always_comb begin
        product = '0;
        for (int j = 0; j < NIBS; j++) product = product + partial[j];
    end

endmodule

// File: rtl/erq_quantizer.sv
// Rounds the loop sum to OUT_W bits by dropping IN_W-OUT_W low bits with
// half-step rounding, saturates at the signed OUT_W limits, and reports the
// error left behind (sum minus the rescaled code). Purely combinational.
module erq_quantizer #(
    parameter int IN_W  = 12,
    parameter int OUT_W = 4,
    parameter int SUM_W = 16,
    parameter int ERR_W = SUM_W + 1
) (
    input  logic signed [SUM_W-1:0] sum_in,
    output logic signed [OUT_W-1:0] code,
    output logic signed [ERR_W-1:0] err
);
    localparam int SHIFT = IN_W - OUT_W;
    localparam logic signed [SUM_W:0] HALF  = (SUM_W+1)'(2 ** (SHIFT - 1));
    localparam logic signed [SUM_W:0] Q_MAX = (SUM_W+1)'(2 ** (OUT_W - 1) - 1);
    localparam logic signed [SUM_W:0] Q_MIN = -(Q_MAX + (SUM_W+1)'(1));

    logic signed [SUM_W:0] rnd;
    logic signed [SUM_W:0] lvl;

    // Round to the nearest level, then clamp to the output range.
    always_comb begin
        rnd = (SUM_W+1)'(sum_in) + HALF;
        lvl = rnd >>> SHIFT;
        if (lvl > Q_MAX)      code = OUT_W'(Q_MAX);
        else if (lvl < Q_MIN) code = OUT_W'(Q_MIN);
        else                  code = OUT_W'(lvl);
    end

    // Error between the loop sum and the value the code stands for.
    always_comb begin
        err = ERR_W'(sum_in) - (ERR_W'(code) <<< SHIFT);
    end

endmodule

// File: rtl/erq_predictor.sv
// Transposed FIR error predictor. Each tap multiplies the current error by
// its weight through a nibble table multiply; the products enter an
// accumulate-delay chain that advances once per accepted sample. The head
// of the chain, rescaled by the coefficient fraction and saturated, is the
// prediction for the next sample, so the predictor has no added latency.
module erq_predictor #(
    parameter int TAPS      = 9,
    parameter int COEF_W    = 12,
    parameter int COEF_FRAC = 10,
    parameter int SUM_W     = 16,
    parameter int ERR_W     = SUM_W + 1,
    parameter int IDX_W     = erq_pkg::index_width(TAPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     advance,
    input  logic                     load_en,
    input  logic [IDX_W-1:0]         load_idx,
    input  logic signed [COEF_W-1:0] load_val,
    input  logic signed [ERR_W-1:0]  err,
    output logic signed [SUM_W-1:0]  pred,
    output logic [TAPS*COEF_W-1:0]   coef_view
);
    localparam int NIB_W  = erq_pkg::NIB_W;
    localparam int DEPTH  = erq_pkg::LUT_DEPTH;
    localparam int ENT_W  = COEF_W + NIB_W;
    localparam int PAD_W  = erq_pkg::nibble_count(ERR_W) * NIB_W;
    localparam int PROD_W = PAD_W + COEF_W;
    localparam int ACC_W  = PROD_W + erq_pkg::index_width(TAPS);
    localparam logic signed [ACC_W-1:0] P_MAX = ACC_W'(2 ** (SUM_W - 1) - 1);
    localparam logic signed [ACC_W-1:0] P_MIN = -P_MAX - ACC_W'(1);

    logic signed [PROD_W-1:0] prod     [TAPS];
    logic signed [ACC_W-1:0]  acc      [TAPS];
    logic signed [ACC_W-1:0]  chain_in [TAPS];
    logic signed [ACC_W-1:0]  scaled;

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        logic [DEPTH*ENT_W-1:0] lut_flat;
        logic                   tap_load;

        assign tap_load = load_en && (load_idx == IDX_W'(k));

        erq_coef_table #(
            .COEF_W (COEF_W),
            .ENT_W  (ENT_W)
        ) u_table (
            .clk          (clk),
            .rst_n        (rst_n),
            .load_en      (tap_load),
            .load_val     (load_val),
            .entries_flat (lut_flat)
        );

        erq_nibble_mult #(
            .OPND_W (ERR_W),
            .COEF_W (COEF_W),
            .ENT_W  (ENT_W),
            .PROD_W (PROD_W)
        ) u_mult (
            .entries_flat (lut_flat),
            .operand      (err),
            .product      (prod[k])
        );

        assign coef_view[k*COEF_W +: COEF_W] = lut_flat[ENT_W +: COEF_W];

        if (k == TAPS - 1) begin : g_tail
            assign chain_in[k] = '0;
        end else begin : g_link
            assign chain_in[k] = acc[k+1];
        end
    end

    // Advance the accumulate-delay chain on every accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < TAPS; k++) acc[k] <= '0;
        end else if (advance) begin
            for (int k = 0; k < TAPS; k++) acc[k] <= ACC_W'(prod[k]) + chain_in[k];
        end
    end

    // Rescale the chain head and saturate it into the loop-sum range.
    always_comb begin
        scaled = acc[0] >>> COEF_FRAC;
        if (scaled > P_MAX)      pred = SUM_W'(P_MAX);
        else if (scaled < P_MIN) pred = SUM_W'(P_MIN);
        else                     pred = SUM_W'(scaled);
    end

endmodule

// File: rtl/erq_requantizer.sv
// Top of the predictive error-feedback requantizer. Adds the predicted error
// to each accepted input, saturates the sum, quantizes it, feeds the error
// back into the predictor and registers the code. Coefficient writes are
// honoured only on cycles without an accepted sample.
module erq_requantizer #(
    parameter int IN_W      = 12,
    parameter int OUT_W     = 4,
    parameter int TAPS      = 9,
    parameter int COEF_W    = 12,
    parameter int COEF_FRAC = 10,
    parameter int GUARD     = 4,
    parameter int IDX_W     = erq_pkg::index_width(TAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_sample,
    input  logic              coef_we,
    input  logic [IDX_W-1:0]  coef_idx,
    input  logic [COEF_W-1:0] coef_val,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_sample
);
    localparam int SUM_W = IN_W + GUARD;
    localparam int ERR_W = SUM_W + 1;
    localparam logic signed [SUM_W:0] S_MAX = (SUM_W+1)'(2 ** (SUM_W - 1) - 1);
    localparam logic signed [SUM_W:0] S_MIN = -S_MAX - (SUM_W+1)'(1);

    logic signed [SUM_W-1:0]   pred_p;
    logic signed [SUM_W:0]     sum_raw;
    logic signed [SUM_W-1:0]   sum_v;
    logic signed [OUT_W-1:0]   q_val;
    logic signed [ERR_W-1:0]   err_val;
    logic [TAPS*COEF_W-1:0]    coef_view;
    logic                      load_ok;

    assign load_ok = coef_we && !in_valid;

    // Combine input and prediction, saturating to the loop-sum width.
    always_comb begin
        sum_raw = (SUM_W+1)'($signed(in_sample)) + (SUM_W+1)'(pred_p);
        if (sum_raw > S_MAX)      sum_v = SUM_W'(S_MAX);
        else if (sum_raw < S_MIN) sum_v = SUM_W'(S_MIN);
        else                      sum_v = SUM_W'(sum_raw);
    end

    erq_quantizer #(
        .IN_W  (IN_W),
        .OUT_W (OUT_W),
        .SUM_W (SUM_W),
        .ERR_W (ERR_W)
    ) u_quant (
        .sum_in (sum_v),
        .code   (q_val),
        .err    (err_val)
    );

    erq_predictor #(
        .TAPS      (TAPS),
        .COEF_W    (COEF_W),
        .COEF_FRAC (COEF_FRAC),
        .SUM_W     (SUM_W),
        .ERR_W     (ERR_W),
        .IDX_W     (IDX_W)
    ) u_pred (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (in_valid),
        .load_en   (load_ok),
        .load_idx  (coef_idx),
        .load_val  ($signed(coef_val)),
        .err       (err_val),
        .pred      (pred_p),
        .coef_view (coef_view)
    );

    // Register the code and its valid flag; hold the code while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_sample <= q_val;
        end
    end

endmodule

// File: rtl/erq_requantizer_checker.sv
// Temporal checks on the requantizer, attached to every instance by bind.
// Observes the valid pipeline, idle behaviour, coefficient freezing,
// the error bound and the quantizer's saturation points.
module erq_requantizer_checker #(
    parameter int IN_W   = 12,
    parameter int OUT_W  = 4,
    parameter int SUM_W  = 16,
    parameter int ERR_W  = 17,
    parameter int CVW    = 108
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic signed [SUM_W-1:0] sum_v,
    input logic signed [SUM_W-1:0] pred_p,
    input logic signed [OUT_W-1:0] q_val,
    input logic signed [ERR_W-1:0] err_val,
    input logic [CVW-1:0]          coef_view
);
    localparam int SHIFT = IN_W - OUT_W;
    localparam int QMAX  = 2 ** (OUT_W - 1) - 1;
    localparam int QMIN  = -(2 ** (OUT_W - 1));
    localparam logic signed [SUM_W-1:0] HI_LIM  = SUM_W'(QMAX * (2 ** SHIFT) - 2 ** (SHIFT - 1));
    localparam logic signed [SUM_W-1:0] LO_LIM  = SUM_W'((QMIN + 1) * (2 ** SHIFT) - 2 ** (SHIFT - 1));
    localparam logic signed [ERR_W-1:0] E_HI    = ERR_W'(2 ** (SHIFT - 1) - 1);
    localparam logic signed [ERR_W-1:0] E_LO    = -ERR_W'(2 ** (SHIFT - 1));
    localparam logic signed [OUT_W-1:0] C_MAX   = OUT_W'(QMAX);
    localparam logic signed [OUT_W-1:0] C_MIN   = OUT_W'(QMIN);

    assert_valid_pipe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(pred_p)));

    assert_coef_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> $stable(coef_view));

    assert_err_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q_val != C_MAX && q_val != C_MIN) |-> (err_val >= E_LO && err_val <= E_HI));

    assert_sat_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_v >= HI_LIM) |-> (q_val == C_MAX));

    assert_sat_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_v < LO_LIM) |-> (q_val == C_MIN));

endmodule

bind erq_requantizer erq_requantizer_checker #(
    .IN_W  (IN_W),
    .OUT_W (OUT_W),
    .SUM_W (SUM_W),
    .ERR_W (ERR_W),
    .CVW   (TAPS * COEF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .sum_v     (sum_v),
    .pred_p    (pred_p),
    .q_val     (q_val),
    .err_val   (err_val),
    .coef_view (coef_view)
);

// File: tb/erq_requantizer_tb.sv
`timescale 1ns/1ps
module erq_requantizer_tb;

    localparam int TAPS = 9;
    localparam int NVEC = 8;
    // First-order loop (a0 = 1.0), constant input 100: expected codes.
    localparam int TV_X [NVEC] = '{100, 100, 100, 100, 100, 100, 100, 100};
    localparam int TV_Y [NVEC] = '{0, 1, 0, 1, 0, 0, 1, 0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_sample = '0;
    logic        coef_we = 1'b0;
    logic [3:0]  coef_idx = '0;
    logic [11:0] coef_val = '0;
    logic        out_valid;
    logic [3:0]  out_sample;

    int n_pass = 0;
    int n_fail = 0;
    bit done = 1'b0;
    longint m_coef [TAPS];
    longint m_acc  [TAPS];
    int unsigned seed = 32'h1234_5678;

    erq_requantizer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .coef_we    (coef_we),
        .coef_idx   (coef_idx),
        .coef_val   (coef_val),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        if (ok) n_pass++;
        else begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint clamp(input longint v, input longint lo, input longint hi);
        return (v > hi) ? hi : ((v < lo) ? lo : v);
    endfunction

    // Arithmetic model from the requirements (R2, R4, R7).
    function automatic int model_step(input int x);
        longint p, v, q, e;
        p = clamp(m_acc[0] >>> 10, -32768, 32767);
        v = clamp(longint'(x) + p, -32768, 32767);
        q = clamp((v + 128) >>> 8, -8, 7);
        e = v - q * 256;
        for (int k = 0; k < TAPS; k++)
            m_acc[k] = e * m_coef[k] + ((k < TAPS - 1) ? m_acc[k+1] : 0);
        return int'(q);
    endfunction

    function automatic int out_code();
        return int'($signed(out_sample));
    endfunction

    task automatic model_clear(input bit coefs);
        for (int k = 0; k < TAPS; k++) begin
            m_acc[k] = 0;
            if (coefs) m_coef[k] = 0;
        end
    endtask

    // Present one sample at a falling edge, check its code one edge later.
    task automatic drive(input int x, input string req);
        int exp;
        in_valid  = 1'b1;
        in_sample = 12'(x);
        exp = model_step(x);
        @(posedge clk);
        @(negedge clk);
        check(out_code() == exp && out_valid, req, out_code(), exp);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input int idx, input int val);
        in_valid = 1'b0;
        coef_we  = 1'b1;
        coef_idx = 4'(idx);
        coef_val = 12'(val);
        @(negedge clk);
        coef_we = 1'b0;
        if (idx < TAPS) m_coef[idx] = val;
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        coef_we  = 1'b0;
        rst_n    = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_clear(1'b1);
    endtask

    function automatic int next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 16) % 4096) - 2048;
    endfunction

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1-R8 actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        model_clear(1'b1);
        @(negedge clk);
        do_reset();
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        check(out_sample == 4'd0, "R1 out_sample after reset", out_code(), 0);

        // R1/R2: zero coefficients give plain rounding with saturation
        drive(2047, "R2 full scale positive saturates to 7");
        drive(-2048, "R2 full scale negative saturates to -8");
        drive(127, "R2 127 rounds to 0");
        drive(128, "R2 128 rounds to 1");
        drive(-128, "R2 -128 rounds to 0");
        drive(-129, "R2 -129 rounds to -1");
        for (int i = 0; i < 6; i++) drive(100, "R1 no feedback after reset");

        // R3/R8: valid drops one edge after input; code holds while idle
        idle(1);
        check(out_valid == 1'b0, "R3 out_valid low after idle edge", out_valid, 0);
        idle(3);
        check(out_code() == 0, "R8 code holds while idle", out_code(), 0);

        // R4/R5: table of first-order vectors (a0 = 1.0)
        load(0, 1024);
        idle(1);
        model_clear(1'b0);
        do_reset();
        load(0, 1024);
        for (int i = 0; i < NVEC; i++) begin
            int dummy;
            in_valid  = 1'b1;
            in_sample = 12'(TV_X[i]);
            dummy = model_step(TV_X[i]);
            @(posedge clk);
            @(negedge clk);
            check(out_code() == TV_Y[i], "R4 first-order vector", out_code(), TV_Y[i]);
        end

        // R8: same sequence with idle gaps gives the same codes
        do_reset();
        load(0, 1024);
        for (int i = 0; i < NVEC; i++) begin
            drive(TV_X[i], "R8 sequence unchanged by idle gaps");
            idle(i % 3);
        end

        // R6: writes during valid samples and to tap 9 are ignored
        do_reset();
        load(9, 2047);
        load(15, -2048);
        for (int i = 0; i < 12; i++) begin
            coef_we  = 1'b1;
            coef_idx = 4'(i % TAPS);
            coef_val = 12'(1024);
            drive(100, "R6 write during valid ignored");
        end
        coef_we = 1'b0;
        idle(1);
        for (int i = 0; i < 6; i++) drive(100, "R6 out-of-range or blocked write ignored");

        // R5: weight on tap 2 acts on e(n-3)
        do_reset();
        load(2, 1024);
        for (int i = 0; i < 16; i++) drive(100, "R5 tap index two delay");

        // R4: highpass centre (a0 = -1.0), alternating input
        do_reset();
        load(0, -1024);
        for (int i = 0; i < 24; i++) drive((i % 2 == 0) ? 300 : -300, "R4 highpass loop");

        // R5: nine-tap weight set with pseudo-random input
        do_reset();
        load(0, 1400); load(1, -900); load(2, 300); load(3, 200); load(4, -150);
        load(5, 80);   load(6, -40);  load(7, 20);  load(8, -10);
        for (int i = 0; i < 200; i++) drive(next_rand() / 4, "R5 nine-tap predictor");

        // R7: maximal weights drive the loop into sum saturation
        do_reset();
        for (int k = 0; k < TAPS; k++) load(k, 2047);
        for (int i = 0; i < 60; i++) drive(2047, "R7 positive sum saturation");
        for (int i = 0; i < 60; i++) drive(-2048, "R7 negative sum saturation");

        // R1: mid-run reset clears state and coefficients
        do_reset();
        check(out_valid == 1'b0 && out_sample == 4'd0, "R1 mid-run reset", out_code(), 0);
        for (int i = 0; i < 8; i++) drive(100, "R1 coefficients cleared by reset");

        idle(2);
        finish_run();
    end

endmodule